// File: doc/BRIEF.md
# Flash streaming block-program engine

This block is the device-side controller for a high-throughput factory programming mode of a NOR flash. A host starts a session with a two-write command sequence on a simple bus: the setup code 0x80, then the confirm code 0xD0. The address of the confirm write becomes the session's anchor address. The engine then spends a programmable number of cycles on setup checks: whether the target block is locked, whether the programming supply is good, and whether the anchor address is aligned to a buffer. It reports the outcome in an 8-bit status word.

When the checks pass, every write whose address equals the anchor address is data for a 32-word write buffer, whatever its value. Every read returns the status word. Once all 32 words are loaded, the engine spends a programmable number of cycles programming them into a behavioural array at an internal word counter. This counter starts at the anchor address and steps through the anchor's block one buffer at a time. Past the end of the block it wraps to the block's first word. Programming can only clear bits. A write to any other address ends the session and throws away any partly filled buffer.

Status bits: 7 = ready (set when no session is running), 4 = setup failed, 3 = supply fault, 1 = block locked, 0 = buffer can accept data.

Top module: `fpb_engine`

## Requirements
- R1: After reset the status is 0x80, and a read outside a session returns the array word at the bus address, which is 0xFFFF for every word.
- R2: A write of 0x80 followed directly by a write of 0xD0 starts a session. The status is then 0x00 for exactly SETUP_CYC cycles.
- R3: When the write after 0x80 is not 0xD0, the engine returns to idle and stays there (status 0x80). A lone 0xD0 written in idle has no effect.
- R4: A failed setup check ends the session in idle with status 0x80|0x10, plus 0x02 for a locked block and 0x08 for a bad supply. An anchor address with nonzero bits [4:0] sets only 0x10. Reads then return array data.
- R5: After a passing setup the status is 0x01, and every read returns the status word. A written value of 0x0070 is stored as data like any other value.
- R6: The array changes only after all 32 words of a buffer have been loaded.
- R7: After the 32nd word, the status is 0x00 for exactly PROG_CYC cycles and then returns to 0x01. Writes during that window have no effect.
- R8: A commit programs each word as the old array word AND the buffered word, in load order, from the word counter upward.
- R9: The word counter starts at the anchor address and advances by 32 after each commit. After the block's last buffer it wraps to the block's first word. No other block is written.
- R10: A write whose address differs from the anchor address ends the session: the status becomes 0x80, the partial buffer is discarded, and reads return array data again.
- R11: Error bits stay set in idle and are cleared by the next confirm write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | AW | Word address for reads and writes |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data: status in a session, array word otherwise |
| lock_map | input | NBLK | Lock flag per block |
| vpp_ok | input | 1 | Programming supply within range |
| status_o | output | 8 | Status word |

## Verification
The bench uses the default configuration: an 8-bit address, 64-word blocks (so four blocks of two buffers each), SETUP_CYC=4, PROG_CYC=8 and AND-style programming. With only two buffers per block, three back-to-back commits reach the wrap to the block start and a second AND onto programmed words. With four blocks, a full sweep of all 256 words after each phase shows that neighbouring blocks stay erased. The lock, supply and alignment failures are each driven, alone and together. The setup and program windows are counted cycle by cycle.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_SETUP,
      ST_STREAM,
      ST_PROG
   } fpb_state_e;

   localparam int SB_READY   = 7;
   localparam int SB_SETERR  = 4;
   localparam int SB_VPPERR  = 3;
   localparam int SB_LOCKERR = 1;
   localparam int SB_BUFRDY  = 0;

   localparam logic [7:0] CMD_SETUP   = 8'h80;
   localparam logic [7:0] CMD_CONFIRM = 8'hD0;
endpackage

// File: rtl/fpb_ctrl.sv
module fpb_ctrl
   import fpb_pkg::*;
#(
   parameter int AW        = 8,
   parameter int OFFW      = 6,
   parameter int BIDX      = 5,
   parameter int NBLK      = 4,
   parameter int SETUP_CYC = 4,
   parameter int PROG_CYC  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [AW-1:0]   addr,
   input  logic [7:0]      wcode,
   input  logic [NBLK-1:0] lock_map,
   input  logic            vpp_ok,
   input  logic [BIDX-1:0] fill,
   output logic            load_en,
   output logic            start,
   output logic            commit,
   output logic            active,
   output logic            in_mode,
   output logic [AW-1:0]   anchor,
   output logic [7:0]      status
);
   localparam int MAXC = (SETUP_CYC > PROG_CYC) ? SETUP_CYC : PROG_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam int BLKW = AW - OFFW;

   fpb_state_e      state;
   logic [CW-1:0]   cnt;
   logic            e_set, e_vpp, e_lock;
   logic            chk_lock, chk_mis, chk_fail, last_word;

   assign chk_lock  = lock_map[anchor[AW-1:OFFW]];
   assign chk_mis   = |anchor[BIDX-1:0];
   assign chk_fail  = chk_lock | ~vpp_ok | chk_mis;
   assign last_word = (fill == BIDX'(2**BIDX - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         anchor <= '0;
         e_set  <= 1'b0;
         e_vpp  <= 1'b0;
         e_lock <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (wr && wcode == CMD_SETUP) state <= ST_CMD;
            end
            ST_CMD: begin
               if (wr) begin
                  if (wcode == CMD_CONFIRM) begin
                     state  <= ST_SETUP;
                     cnt    <= CW'(SETUP_CYC - 1);
                     anchor <= addr;
                     e_set  <= 1'b0;
                     e_vpp  <= 1'b0;
                     e_lock <= 1'b0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_SETUP: begin
               if (cnt == '0) begin
                  if (chk_fail) begin
                     state  <= ST_IDLE;
                     e_set  <= 1'b1;
                     e_vpp  <= ~vpp_ok;
                     e_lock <= chk_lock;
                  end else begin
                     state <= ST_STREAM;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_STREAM: begin
               if (wr) begin
                  if (addr != anchor) begin
                     state <= ST_IDLE;
                  end else if (last_word) begin
                     state <= ST_PROG;
                     cnt   <= CW'(PROG_CYC - 1);
                  end
               end
            end
            ST_PROG: begin
               if (cnt == '0) state <= ST_STREAM;
               else           cnt   <= cnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      load_en = (state == ST_STREAM) && wr && (addr == anchor);
      start   = (state == ST_CMD) && wr && (wcode == CMD_CONFIRM);
      commit  = (state == ST_PROG) && (cnt == '0);
      active  = (state == ST_STREAM) || (state == ST_PROG);
      in_mode = active || (state == ST_SETUP);
      status             = '0;
      status[SB_READY]   = (state == ST_IDLE) || (state == ST_CMD);
      status[SB_SETERR]  = e_set;
      status[SB_VPPERR]  = e_vpp;
      status[SB_LOCKERR] = e_lock;
      status[SB_BUFRDY]  = (state == ST_STREAM);
   end

   p_err_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      e_set |-> (state == ST_IDLE || state == ST_CMD));

   p_prog_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROG && $past(state) == ST_STREAM) |-> $past(fill) == BIDX'(2**BIDX - 1));

   p_prog_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROG && cnt == '0) |=> (state == ST_STREAM));

   p_anchor_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !start) |=> $stable(anchor[AW-1:AW-BLKW]));
endmodule

// File: rtl/fpb_wbuf.sv
module fpb_wbuf #(
   parameter int DW        = 16,
   parameter int BUF_WORDS = 32,
   parameter int BIDX      = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           active,
   input  logic                           load_en,
   input  logic [DW-1:0]                  wdata,
   output logic [BIDX-1:0]                fill,
   output logic [BUF_WORDS-1:0][DW-1:0]   words
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
         for (int i = 0; i < BUF_WORDS; i++) words[i] <= '1;
      end else if (!active) begin
         fill <= '0;
      end else if (load_en) begin
         words[fill] <= wdata;
         fill        <= fill + 1'b1;
      end
   end

   p_clear_on_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |=> (fill == '0));
endmodule

// File: rtl/fpb_array.sv
module fpb_array #(
   parameter int DW        = 16,
   parameter int AW        = 8,
   parameter int OFFW      = 6,
   parameter int BIDX      = 5,
   parameter int BUF_WORDS = 32,
   parameter bit PROG_AND  = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic                           active,
   input  logic                           commit,
   input  logic [AW-1:0]                  anchor_d,
   input  logic [BUF_WORDS-1:0][DW-1:0]   words,
   input  logic [AW-1:0]                  rd_addr,
   output logic [DW-1:0]                  rd_data
);
   localparam int BLKW  = AW - OFFW;
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0]   mem [0:DEPTH-1];
   logic [BLKW-1:0] blk;
   logic [OFFW-1:0] off;
   logic [AW-1:0]   waddr [BUF_WORDS];
   logic [DW-1:0]   nval  [BUF_WORDS];

   for (genvar g = 0; g < BUF_WORDS; g++) begin : g_lane
      logic [OFFW-1:0] off_g;
      assign off_g    = off + OFFW'(g);
      assign waddr[g] = {blk, off_g};
      if (PROG_AND) begin : g_and
         assign nval[g] = mem[waddr[g]] & words[g];
      end else begin : g_ovr
         assign nval[g] = words[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk <= '0;
         off <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (start) begin
         blk <= anchor_d[AW-1:OFFW];
         off <= anchor_d[OFFW-1:0];
      end else if (commit) begin
         for (int i = 0; i < BUF_WORDS; i++) mem[waddr[i]] <= nval[i];
         off <= off + OFFW'(BUF_WORDS);
      end
   end

   assign rd_data = mem[rd_addr];

   p_commit_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (off[BIDX-1:0] == '0));

   p_blk_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !start) |=> $stable(blk));
endmodule

// File: rtl/fpb_engine.sv
module fpb_engine
   import fpb_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 8,
   parameter int BLK_WORDS = 64,
   parameter int BUF_WORDS = 32,
   parameter int SETUP_CYC = 4,
   parameter int PROG_CYC  = 8,
   parameter bit PROG_AND  = 1'b1,
   localparam int NBLK     = (1 << AW) / BLK_WORDS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic [NBLK-1:0] lock_map,
   input  logic            vpp_ok,
   output logic [7:0]      status_o
);
   localparam int OFFW = $clog2(BLK_WORDS);
   localparam int BIDX = $clog2(BUF_WORDS);

   if (DW < 8)                              $error("DW must be at least 8");
   if ((1 << BIDX) != BUF_WORDS)            $error("BUF_WORDS must be a power of two");
   if ((1 << OFFW) != BLK_WORDS)            $error("BLK_WORDS must be a power of two");
   if (BLK_WORDS < BUF_WORDS)               $error("block smaller than buffer");
   if (NBLK < 2)                            $error("need at least two blocks");
   if (SETUP_CYC < 1 || PROG_CYC < 1)       $error("delays must be at least one cycle");

   logic                          load_en, start, commit, active, in_mode;
   logic [AW-1:0]                 anchor;
   logic [BIDX-1:0]               fill;
   logic [BUF_WORDS-1:0][DW-1:0]  words;
   logic [DW-1:0]                 arr_rd;
   logic [7:0]                    status;

   fpb_ctrl #(
      .AW(AW), .OFFW(OFFW), .BIDX(BIDX), .NBLK(NBLK),
      .SETUP_CYC(SETUP_CYC), .PROG_CYC(PROG_CYC)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wcode(bus_wdata[7:0]), .lock_map(lock_map), .vpp_ok(vpp_ok),
      .fill(fill), .load_en(load_en), .start(start), .commit(commit),
      .active(active), .in_mode(in_mode), .anchor(anchor), .status(status)
   );

   fpb_wbuf #(.DW(DW), .BUF_WORDS(BUF_WORDS), .BIDX(BIDX)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .active(active), .load_en(load_en),
      .wdata(bus_wdata), .fill(fill), .words(words)
   );

   fpb_array #(
      .DW(DW), .AW(AW), .OFFW(OFFW), .BIDX(BIDX),
      .BUF_WORDS(BUF_WORDS), .PROG_AND(PROG_AND)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .start(start), .active(active),
      .commit(commit), .anchor_d(bus_addr), .words(words),
      .rd_addr(bus_addr), .rd_data(arr_rd)
   );

   assign status_o  = status;
   assign bus_rdata = in_mode ? {{(DW-8){1'b0}}, status} : arr_rd;

   p_mode_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_mode |-> !status_o[SB_READY]);
endmodule

// File: tb/test_fpb_engine.sv
`timescale 1ns/1ps
module test_fpb_engine;
   localparam int DW = 16, AW = 8, BLKW = 64, BUFW = 32, SCYC = 4, PCYC = 8;
   localparam int NB = (1 << AW) / BLKW;

   logic          clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, vpp_ok = 1'b1;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0, bus_rdata;
   logic [NB-1:0] lock_map = '0;
   logic [7:0]    status_o;

   int total = 0, bad = 0;
   bit done = 1'b0;
   logic [DW-1:0] exp_mem [0:(1<<AW)-1];

   always #2 clk = ~clk;

   fpb_engine #(.DW(DW), .AW(AW), .BLK_WORDS(BLKW), .BUF_WORDS(BUFW),
                .SETUP_CYC(SCYC), .PROG_CYC(PCYC)) i_fpb_engine (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_map(lock_map),
      .vpp_ok(vpp_ok), .status_o(status_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic sweep(input string req);
      int errs = 0;
      logic [DW-1:0] d;
      for (int i = 0; i < (1 << AW); i++) begin
         rd(AW'(i), d);
         if (d !== exp_mem[i]) begin
            errs++;
            if (errs == 1) $display("FAIL %s word %0d act=%h exp=%h", req, i, d, exp_mem[i]);
         end
      end
      total++;
      if (errs != 0) bad++;
   endtask

   // R2: setup window length, then final status
   task automatic enter(input logic [AW-1:0] a, input logic [7:0] fin);
      int n = 0;
      wr(a, 16'h0080);
      wr(a, 16'h00D0);
      while (status_o == 8'h00 && n < 100) begin n++; @(negedge clk); end
      check("R2 setup cycles", n, SCYC);
      check("R4/R5 status after setup", status_o, fin);
   endtask

   function automatic logic [DW-1:0] pat(input int k, input int i);
      if (k == 0 && i == 0) return 16'h0070;
      return DW'((k * 16'h0123) ^ (i * 16'h0101) ^ 16'hA5F0);
   endfunction

   // stream one full buffer k into session anchored at wa, committing at block offset off
   task automatic fill_buf(input logic [AW-1:0] wa, input int k, input int base);
      int n = 0;
      logic [DW-1:0] d;
      for (int i = 0; i < BUFW; i++) begin
         wr(wa, pat(k, i));
         if (i == 10) begin
            check("R5 status while streaming", status_o, 8'h01);
            rd(wa + 8'd3, d);
            check("R5 read returns status", d, 16'h0001);
         end
      end
      check("R7 program window start", status_o, 8'h00);
      wr(wa, 16'h0000);               // R7: ignored during program window
      while (status_o == 8'h00 && n < 100) begin n++; @(negedge clk); end
      check("R7 program cycles", n, PCYC - 1);
      check("R7 status after program", status_o, 8'h01);
      for (int i = 0; i < BUFW; i++) exp_mem[base + i] = exp_mem[base + i] & pat(k, i);
   endtask

   initial begin
      logic [DW-1:0] d;
      for (int i = 0; i < (1 << AW); i++) exp_mem[i] = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 reset status", status_o, 8'h80);
      sweep("R1 erased array");

      // R3: broken sequence and lone confirm
      wr(8'h00, 16'h0080);
      wr(8'h00, 16'h0040);
      repeat (2) @(negedge clk);
      check("R3 broken sequence", status_o, 8'h80);
      wr(8'h00, 16'h00D0);
      repeat (2) @(negedge clk);
      check("R3 lone confirm", status_o, 8'h80);

      // R4: lock, supply, both, misalignment
      lock_map = 4'b0010;
      enter(8'h40, 8'h92);
      rd(8'h40, d);
      check("R4 read array after fail", d, 16'hFFFF);
      lock_map = 4'b0000; vpp_ok = 1'b0;
      enter(8'h00, 8'h98);
      lock_map = 4'b0010;
      enter(8'h40, 8'h9A);
      lock_map = 4'b0000; vpp_ok = 1'b1;
      enter(8'h03, 8'h90);
      sweep("R4 array untouched after fails");

      // R11 + R5: good session in block 2
      enter(8'h80, 8'h01);
      check("R11 errors cleared", status_o[4:1], 4'h0);
      fill_buf(8'h80, 0, 8'h80);      // R8 includes 0x0070 as data
      fill_buf(8'h80, 1, 8'hA0);
      fill_buf(8'h80, 2, 8'h80);      // R9 wrap to block start, AND onto old
      // R6 + R10: partial buffer then exit
      for (int i = 0; i < 10; i++) wr(8'h80, 16'h0000);
      check("R6 partial keeps accepting", status_o, 8'h01);
      wr(8'h81, 16'h1234);
      check("R10 exit status", status_o, 8'h80);
      rd(8'h80, d);
      check("R10 read returns array", d, exp_mem[8'h80]);
      sweep("R6 R8 R9 R10 array contents");

      // R9: new session restarts at anchor; other block, AND result
      enter(8'hE0, 8'h01);
      fill_buf(8'hE0, 5, 8'hE0);
      wr(8'h00, 16'h0000);
      check("R10 exit second session", status_o, 8'h80);
      sweep("R8 R9 second block");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule